// File: doc/BRIEF.md
# Inbound Requester-to-Partition Classifier

This block sits on the inbound side of a PCI Express host bridge and tags each upstream request with the isolation partition that owns it. Every request carries a 16-bit requester ID (bus, device, function), and a local mapping table turns that ID into an 8-bit partition number. Memory reads, memory writes and error messages all take their partition from this table. The partition is never taken from the address.

Memory requests that miss both interrupt windows are direct memory accesses. For these, address bit 59 selects one of two windows in the partition's address space. A memory write that lands in one of the two message-signalled interrupt windows is an interrupt. One window sits just below 4 GiB and the other sits high in the 64-bit space. The interrupt number comes from the message data and the window that was hit. The block then looks up that interrupt number in a descriptor table that records which partition may raise it. The interrupt is authorized only when the two partition numbers agree. Otherwise the interrupt is dropped and a rejection strobe reports the requester ID and the interrupt number.

Both tables are local RAMs that software fills through dedicated write ports. The block takes one request per cycle. Each result appears two cycles after the request, and results leave in the order the requests arrived.

Top module: `inbound_part_classifier`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_fire and rej_valid are all low.
- R2: Every accepted request produces exactly one output two clock edges after it is sampled. out_part holds the mapping-table entry at index rid[RID_IDX_W-1:0].
- R3: A memory read (type 0), or a memory write (type 1) that misses both interrupt windows, gives kind 0 (read) or kind 1 (write). out_win equals address bit 59, out_irq is 0, and neither out_fire nor rej_valid is raised.
- R4: The interrupt windows are hit when address bits [63:16] equal those of 0x0000_0000_FFFF_0000 (low window) or of 0x0003_0000_0000_0000 (high window). A memory write that hits a window gives kind 2, with out_win 0 for the low window and 1 for the high window. A memory read inside a window stays kind 0.
- R5: The interrupt number is data[10:0] for the low window. For the high window it is data[10:0] + 1024, wrapped modulo 2048. Data bits above bit 10 are ignored.
- R6: For kind 2, out_fire is high exactly when the descriptor entry for out_irq equals the partition looked up from the requester ID.
- R7: For kind 2 with a partition mismatch, rej_valid pulses for that one output cycle with rej_rid equal to the requester ID and rej_irq equal to the interrupt number, and out_fire stays low. rej_valid and out_fire are never high together.
- R8: An error message (type 2) gives kind 3 with the looked-up partition, out_win 0 and out_irq 0, and neither out_fire nor rej_valid is raised.
- R9: Type 3 requests are discarded and produce no output.
- R10: A table write takes effect for any request sampled at the following clock edge or later.
- R11: Requests on consecutive cycles each produce their own output on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_type | input | 2 | 0 memory read, 1 memory write, 2 error message, 3 reserved |
| in_rid | input | 16 | Requester ID |
| in_addr | input | 64 | Request address |
| in_data | input | 32 | Write data (interrupt message data) |
| map_wr_en | input | 1 | Mapping-table write strobe |
| map_wr_idx | input | RID_IDX_W | Mapping-table index |
| map_wr_part | input | 8 | Partition written to the mapping table |
| desc_wr_en | input | 1 | Descriptor-table write strobe |
| desc_wr_irq | input | 11 | Descriptor index (interrupt number) |
| desc_wr_part | input | 8 | Partition allowed to raise that interrupt |
| out_valid | output | 1 | Classification result present |
| out_kind | output | 2 | 0 DMA read, 1 DMA write, 2 interrupt, 3 error message |
| out_part | output | 8 | Partition from the requester-ID lookup |
| out_win | output | 1 | DMA window (bit 59) or interrupt window (1 = high) |
| out_irq | output | 11 | Interrupt number, 0 for other kinds |
| out_fire | output | 1 | Authorized interrupt |
| rej_valid | output | 1 | Interrupt dropped on partition mismatch |
| rej_rid | output | 16 | Requester ID of the dropped interrupt |
| rej_irq | output | 11 | Interrupt number of the dropped interrupt |

## Verification
The assertions check several rules on every cycle. out_fire and rej_valid are never high together, and either one appears only on an interrupt result. A rejection always carries the same interrupt number as the result it belongs to. Error-message results never authorize or reject anything. A DMA result's window matches bit 59 of the request two cycles earlier, and every output traces back to a non-reserved request two cycles earlier. Some behaviour needs table contents chosen by the bench, so only its scenarios can show it: the actual partition values, the interrupt-number arithmetic including the wrap in the high window, the match decision itself, and a table write seen by the very next request.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int RID_W  = 16;
    localparam int PART_W = 8;
    localparam int IRQ_W  = 11;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REQ_MEM_RD  = 2'd0,
        REQ_MEM_WR  = 2'd1,
        REQ_ERR_MSG = 2'd2,
        REQ_RSVD    = 2'd3
    } req_type_e;

    typedef enum logic [1:0] {
        CLS_DMA_RD = 2'd0,
        CLS_DMA_WR = 2'd1,
        CLS_MSI    = 2'd2,
        CLS_ERR    = 2'd3
    } cls_kind_e;

    typedef struct packed {
        cls_kind_e          kind;
        logic               win;
        logic [IRQ_W-1:0]   irq;
        logic [RID_W-1:0]   rid;
    } cls_info_t;

    // Window match: address and base agree above the window size.
    function automatic logic win_match(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input int                size_log2);
        logic [ADDR_W-1:0] mask;
        mask = ~((ADDR_W'(1) << size_log2) - ADDR_W'(1));
        return (addr & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/ipc_ram.sv
module ipc_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read-first: a read and a write to the same entry in one cycle
    // return the old contents.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/ipc_req_decode.sv
module ipc_req_decode
    import ipc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MSI_LO_BASE   = 64'h0000_0000_FFFF_0000,
    parameter logic [ADDR_W-1:0] MSI_HI_BASE   = 64'h0003_0000_0000_0000,
    parameter int                MSI_WIN_LOG2  = 16,
    parameter int                HI_IRQ_OFFSET = 1024,
    parameter int                DMA_WIN_BIT   = 59
) (
    input  logic [1:0]        req_type,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              accept,
    output cls_info_t         info
);
    localparam logic [IRQ_W-1:0] HI_OFF = IRQ_W'(HI_IRQ_OFFSET);

    logic hit_lo;
    logic hit_hi;
    logic is_msi;
    logic [IRQ_W-1:0] base_irq;

    always_comb begin
        hit_lo   = win_match(req_addr, MSI_LO_BASE, MSI_WIN_LOG2);
        hit_hi   = win_match(req_addr, MSI_HI_BASE, MSI_WIN_LOG2);
        is_msi   = (req_type == REQ_MEM_WR) && (hit_lo || hit_hi);
        base_irq = req_data[IRQ_W-1:0];

        accept    = (req_type != REQ_RSVD);
        info.rid  = req_rid;
        info.win  = 1'b0;
        info.irq  = '0;
        info.kind = CLS_ERR;

        unique case (req_type)
            REQ_MEM_RD: begin
                info.kind = CLS_DMA_RD;
                info.win  = req_addr[DMA_WIN_BIT];
            end
            REQ_MEM_WR: begin
                if (is_msi) begin
                    info.kind = CLS_MSI;
                    info.win  = hit_hi;
                    info.irq  = hit_hi ? (base_irq + HI_OFF) : base_irq;
                end else begin
                    info.kind = CLS_DMA_WR;
                    info.win  = req_addr[DMA_WIN_BIT];
                end
            end
            REQ_ERR_MSG: info.kind = CLS_ERR;
            default:     info.kind = CLS_ERR;
        endcase
    end
endmodule

// File: rtl/inbound_part_classifier.sv
module inbound_part_classifier
    import ipc_pkg::*;
#(
    parameter int                RID_IDX_W     = 8,
    parameter logic [ADDR_W-1:0] MSI_LO_BASE   = 64'h0000_0000_FFFF_0000,
    parameter logic [ADDR_W-1:0] MSI_HI_BASE   = 64'h0003_0000_0000_0000,
    parameter int                MSI_WIN_LOG2  = 16,
    parameter int                HI_IRQ_OFFSET = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_type,
    input  logic [15:0]          in_rid,
    input  logic [63:0]          in_addr,
    input  logic [31:0]          in_data,
    input  logic                 map_wr_en,
    input  logic [RID_IDX_W-1:0] map_wr_idx,
    input  logic [7:0]           map_wr_part,
    input  logic                 desc_wr_en,
    input  logic [10:0]          desc_wr_irq,
    input  logic [7:0]           desc_wr_part,
    output logic                 out_valid,
    output logic [1:0]           out_kind,
    output logic [7:0]           out_part,
    output logic                 out_win,
    output logic [10:0]          out_irq,
    output logic                 out_fire,
    output logic                 rej_valid,
    output logic [15:0]          rej_rid,
    output logic [10:0]          rej_irq
);
    logic      dec_accept;
    cls_info_t dec_info;

    ipc_req_decode #(
        .MSI_LO_BASE  (MSI_LO_BASE),
        .MSI_HI_BASE  (MSI_HI_BASE),
        .MSI_WIN_LOG2 (MSI_WIN_LOG2),
        .HI_IRQ_OFFSET(HI_IRQ_OFFSET)
    ) u_decode (
        .req_type(in_type),
        .req_rid (in_rid),
        .req_addr(in_addr),
        .req_data(in_data),
        .accept  (dec_accept),
        .info    (dec_info)
    );

    logic              take;
    logic [PART_W-1:0] map_q;
    logic [PART_W-1:0] desc_q;

    assign take = in_valid && dec_accept;

    ipc_ram #(.AW(RID_IDX_W), .DW(PART_W)) u_map (
        .clk    (clk),
        .wr_en  (map_wr_en),
        .wr_addr(map_wr_idx),
        .wr_data(map_wr_part),
        .rd_en  (take),
        .rd_addr(in_rid[RID_IDX_W-1:0]),
        .rd_q   (map_q)
    );

    ipc_ram #(.AW(IRQ_W), .DW(PART_W)) u_desc (
        .clk    (clk),
        .wr_en  (desc_wr_en),
        .wr_addr(desc_wr_irq),
        .wr_data(desc_wr_part),
        .rd_en  (take),
        .rd_addr(dec_info.irq),
        .rd_q   (desc_q)
    );

    // Stage A: decoded request alongside the table reads.
    logic      a_valid;
    cls_info_t a_info;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_info  <= '0;
        end else begin
            a_valid <= take;
            if (take) begin
                a_info <= dec_info;
            end
        end
    end

    // Stage B: authorization and registered results.
    logic a_is_msi;
    logic a_match;

    always_comb begin
        a_is_msi = (a_info.kind == CLS_MSI);
        a_match  = (map_q == desc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_part  <= '0;
            out_win   <= 1'b0;
            out_irq   <= '0;
            out_fire  <= 1'b0;
            rej_valid <= 1'b0;
            rej_rid   <= '0;
            rej_irq   <= '0;
        end else begin
            out_valid <= a_valid;
            out_fire  <= a_valid && a_is_msi && a_match;
            rej_valid <= a_valid && a_is_msi && !a_match;
            if (a_valid) begin
                out_kind <= a_info.kind;
                out_part <= map_q;
                out_win  <= a_info.win;
                out_irq  <= a_info.irq;
                rej_rid  <= a_info.rid;
                rej_irq  <= a_info.irq;
            end
        end
    end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  in_type,
    input logic [63:0] in_addr,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic        out_win,
    input logic [10:0] out_irq,
    input logic        out_fire,
    input logic        rej_valid,
    input logic [10:0] rej_irq
);
    // R7: authorize and reject are exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_fire && rej_valid));

    // R6: authorization only on interrupt results
    a_r6_fire_is_msi: assert property (@(posedge clk) disable iff (rst)
        out_fire |-> (out_valid && out_kind == 2'd2));

    // R7: rejection only on interrupt results, same interrupt number
    a_r7_rej_is_msi: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> (out_valid && out_kind == 2'd2 && rej_irq == out_irq));

    // R8: error messages neither authorize nor reject
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd3) |-> (!out_fire && !rej_valid && out_irq == 11'd0 && !out_win));

    // R3: DMA window follows address bit 59 two cycles earlier
    a_r3_dma_window: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind[1] == 1'b0) |-> (out_win == $past(in_addr[59], 2)));

    // R9: every output comes from a non-reserved request two cycles earlier
    a_r9_source: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid, 2) && $past(in_type, 2) != 2'd3));
endmodule

bind inbound_part_classifier ipc_checker u_ipc_checker (.*);

// File: tb/inbound_part_classifier_test.sv
`timescale 1ns/1ps
module inbound_part_classifier_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_type = 2'd0;
    logic [15:0] in_rid = '0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        map_wr_en = 1'b0;
    logic [7:0]  map_wr_idx = '0;
    logic [7:0]  map_wr_part = '0;
    logic        desc_wr_en = 1'b0;
    logic [10:0] desc_wr_irq = '0;
    logic [7:0]  desc_wr_part = '0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [7:0]  out_part;
    logic        out_win;
    logic [10:0] out_irq;
    logic        out_fire;
    logic        rej_valid;
    logic [15:0] rej_rid;
    logic [10:0] rej_irq;

    int checks = 0;
    int bad = 0;

    localparam logic [63:0] LO_WIN = 64'h0000_0000_FFFF_0010;
    localparam logic [63:0] HI_WIN = 64'h0003_0000_0000_0040;

    always #2.5 clk = ~clk;

    inbound_part_classifier uut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic map_write(input logic [7:0] idx, input logic [7:0] part);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_idx = idx; map_wr_part = part;
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic desc_write(input logic [10:0] irq, input logic [7:0] part);
        @(negedge clk);
        desc_wr_en = 1'b1; desc_wr_irq = irq; desc_wr_part = part;
        @(negedge clk);
        desc_wr_en = 1'b0;
    endtask

    // Drive one request, return at the negedge where its result is visible.
    task automatic send(input logic [1:0] t, input logic [15:0] rid,
                        input logic [63:0] addr, input logic [31:0] data);
        @(negedge clk);
        in_valid = 1'b1; in_type = t; in_rid = rid; in_addr = addr; in_data = data;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [1:0] kind,
                              input logic [7:0] part, input logic win,
                              input logic [10:0] irq, input logic fire,
                              input logic rej);
        chk(req, "out_valid", out_valid, 1'b1);
        chk(req, "out_kind", out_kind, kind);
        chk(req, "out_part", out_part, part);
        chk(req, "out_win", out_win, win);
        chk(req, "out_irq", out_irq, irq);
        chk(req, "out_fire", out_fire, fire);
        chk(req, "rej_valid", rej_valid, rej);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "out_valid in reset", out_valid, 1'b0);
        chk("R1", "out_fire in reset", out_fire, 1'b0);
        chk("R1", "rej_valid in reset", rej_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", out_valid, 1'b0);
        chk("R1", "rej_valid after reset", rej_valid, 1'b0);
    endtask

    task automatic t_setup;
        map_write(8'h12, 8'h05);
        map_write(8'h34, 8'h09);
        map_write(8'h56, 8'h21);
        map_write(8'h78, 8'h40);
        desc_write(11'h007, 8'h05);
        desc_write(11'h407, 8'h09);
        desc_write(11'h100, 8'h09);
    endtask

    task automatic t_dma;
        send(2'd0, 16'h0312, 64'h0800_0000_1234_0000, 32'h0);
        expect_out("R2 R3 dma read win1", 2'd0, 8'h05, 1'b1, 11'd0, 1'b0, 1'b0);
        send(2'd1, 16'h0334, 64'h0000_0010_0000_0000, 32'hFFFF_FFFF);
        expect_out("R2 R3 dma write win0", 2'd1, 8'h09, 1'b0, 11'd0, 1'b0, 1'b0);
        send(2'd0, 16'h0312, LO_WIN, 32'h7);
        expect_out("R4 read in msi window", 2'd0, 8'h05, 1'b0, 11'd0, 1'b0, 1'b0);
    endtask

    task automatic t_msi_ok;
        send(2'd1, 16'h0312, LO_WIN, 32'hABCD_0007);
        expect_out("R4 R5 R6 msi low", 2'd2, 8'h05, 1'b0, 11'h007, 1'b1, 1'b0);
        send(2'd1, 16'h0334, HI_WIN, 32'h0000_0007);
        expect_out("R4 R5 R6 msi high", 2'd2, 8'h09, 1'b1, 11'h407, 1'b1, 1'b0);
        send(2'd1, 16'h0334, HI_WIN, 32'h0000_0500);
        expect_out("R5 msi high wrap", 2'd2, 8'h09, 1'b1, 11'h100, 1'b1, 1'b0);
    endtask

    task automatic t_msi_reject;
        send(2'd1, 16'h0334, LO_WIN, 32'h7);
        expect_out("R7 msi reject", 2'd2, 8'h09, 1'b0, 11'h007, 1'b0, 1'b1);
        chk("R7", "rej_rid", rej_rid, 16'h0334);
        chk("R7", "rej_irq", rej_irq, 11'h007);
        @(negedge clk);
        chk("R7", "rej_valid single pulse", rej_valid, 1'b0);
    endtask

    task automatic t_err_rsvd;
        send(2'd2, 16'h0356, HI_WIN, 32'h7);
        expect_out("R8 error message", 2'd3, 8'h21, 1'b0, 11'd0, 1'b0, 1'b0);
        send(2'd3, 16'h0312, LO_WIN, 32'h7);
        chk("R9", "reserved type out_valid", out_valid, 1'b0);
        chk("R9", "reserved type out_fire", out_fire, 1'b0);
    endtask

    task automatic t_table_update;
        send(2'd1, 16'h0078, LO_WIN, 32'h7);
        expect_out("R10 before rewrite", 2'd2, 8'h40, 1'b0, 11'h007, 1'b0, 1'b1);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_idx = 8'h78; map_wr_part = 8'h05;
        @(negedge clk);
        map_wr_en = 1'b0;
        in_valid = 1'b1; in_type = 2'd1; in_rid = 16'h0078; in_addr = LO_WIN; in_data = 32'h7;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        expect_out("R10 after rewrite", 2'd2, 8'h05, 1'b0, 11'h007, 1'b1, 1'b0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; in_type = 2'd0; in_rid = 16'h0312; in_addr = 64'h0800_0000_0000_0000;
        @(negedge clk);
        in_type = 2'd2; in_rid = 16'h0356; in_addr = '0;
        @(negedge clk);
        in_type = 2'd1; in_rid = 16'h0334; in_addr = HI_WIN; in_data = 32'h7;
        expect_out("R11 first", 2'd0, 8'h05, 1'b1, 11'd0, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R11 second", 2'd3, 8'h21, 1'b0, 11'd0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R11 third", 2'd2, 8'h09, 1'b1, 11'h407, 1'b1, 1'b0);
        @(negedge clk);
        chk("R11", "idle after burst", out_valid, 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_setup();
                t_dma();
                t_msi_ok();
                t_msi_reject();
                t_err_rsvd();
                t_table_update();
                t_back_to_back();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule